// File: doc/BRIEF.md
# Split Unaligned Access Tracker

This block sits between a load/store scheduler and one data-cache port. It accepts one memory access at a time. When the access is marked as crossing an alignment boundary, it sends it to the port as two sub-requests. The low part covers the first `req_lo_size` bytes. The high part covers the remaining bytes, starting at the request address plus `req_lo_size`. An access that is not split goes out as a single sub-request of the full size.

The block keeps an outstanding count for the access. The count is loaded with 1 for a single sub-request and 2 for a split pair. Every response decrements it. Each response's bytes are merged into one data register, at the byte offset its part occupies within the whole access. When the count reaches zero, a one-cycle done pulse reports the original request's address and size together with the merged data.

A port refusal is handled according to which part was refused:
- If the low part is refused, the whole access is abandoned and a retry is signalled.
- If only the high part is refused, a retry is signalled and the count is reduced by one. The access then still finishes when the low part returns.

Load-linked accesses are never split.

Top module: `sat_tracker`

## Requirements
- R1: A split access issues a low part at `req_addr` with size `req_lo_size`, and a high part at `req_addr + req_lo_size` with size `req_size - req_lo_size`. The high part's response bytes land in the merged data starting at byte offset `req_lo_size`. Only the first `len` bytes of a response are used, where `len` is the size of its part. Byte i of any data bus sits at bits [8i+7:8i].
- R2: A part code of 0 means low and 1 means high, on both `pa_part` and `rsp_part`. The low (or only) sub-request is presented in the cycle after the request is accepted. The high part is presented in the cycle after the low part is accepted, and never otherwise.
- R3: `req_ready` is high only while no access is in progress. An unsplit access presents exactly one sub-request (part 0) carrying the full address and size.
- R4: The outstanding count starts at 1 (unsplit) or 2 (split), and each counted response removes one. `done` is a single-cycle pulse in the cycle after the edge at which the count reaches zero, and it fires exactly once per completed access.
- R5: If the port refuses the low part (`pa_accept` low while it is presented), the following happens:
  - no high part is sent;
  - `retry` pulses for one cycle in the next cycle;
  - `done` never fires for that access;
  - the block returns to idle.
- R6: If the port refuses the high part, `retry` pulses in the next cycle and the count drops by one. `done` then fires once the low response has been counted, including when that response arrives in the same cycle as the refusal.
- R7: `ports_used` counts the sub-requests presented to the port for the current access, whether or not they were accepted. It ends at 2 for a split access whose low part was accepted, and at 1 otherwise. It clears when a new request is accepted.
- R8: During the `done` pulse, `done_addr` and `done_size` carry the original request's address and size (not either half), and `done_data` carries the merged bytes.
- R9: A request with `req_linked` high is issued unsplit even when `req_split` is high.
- R10: A response that arrives while the block is idle, or while the first sub-request is still being presented, is ignored. It changes neither the count nor the merged data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | New access offered |
| req_ready | output | 1 | Block idle, access taken this cycle |
| req_addr | input | AW | Byte address of the whole access |
| req_size | input | SW | Total size in bytes |
| req_split | input | 1 | Access crosses a boundary and must be split |
| req_lo_size | input | SW | Byte count of the low part |
| req_linked | input | 1 | Load-linked access, never split |
| pa_valid | output | 1 | Sub-request presented to the cache port |
| pa_part | output | 1 | 0 low/only part, 1 high part |
| pa_addr | output | AW | Sub-request byte address |
| pa_size | output | SW | Sub-request byte count |
| pa_accept | input | 1 | Port takes the presented sub-request this cycle |
| rsp_valid | input | 1 | Sub-request response |
| rsp_part | input | 1 | Which part the response belongs to |
| rsp_data | input | DW | Response bytes, right-justified |
| retry | output | 1 | One-cycle retry request to the scheduler |
| done | output | 1 | One-cycle completion pulse |
| done_addr | output | AW | Address of the completed access |
| done_size | output | SW | Size of the completed access |
| done_data | output | DW | Merged data of the completed access |
| ports_used | output | 2 | Sub-requests presented for the current access |

## Verification
The checker enforces several rules on every cycle:
- a high part is only ever presented right after an accepted low part;
- every refusal is followed by a retry pulse, and a refused low part leaves the port quiet;
- `done` never lasts two cycles;
- the count and `ports_used` never exceed two;
- a load-linked access never shows a high part.

Other behaviours need the bench's scenarios, because they depend on data and on response order. These are the byte placement of the high half, completion after a high refusal, completion when a low response coincides with the refusal, and the absence of completion after a low refusal. The bench compares every output against a behavioural model on every clock and checks the merged bytes against an address-derived pattern.

// File: rtl/sat_pkg.sv
package sat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LO   = 2'd1,
    ST_HI   = 2'd2,
    ST_WAIT = 2'd3
  } sat_state_e;

  localparam logic PART_LO = 1'b0;
  localparam logic PART_HI = 1'b1;
endpackage

// File: rtl/sat_planner.sv
module sat_planner #(
  parameter int AW = 32,
  parameter int SW = 4
) (
  input  logic [AW-1:0] base_addr,
  input  logic [SW-1:0] total,
  input  logic [SW-1:0] lo_size,
  input  logic          split,
  input  logic          iss_part,
  input  logic          rsp_part,
  output logic [AW-1:0] iss_addr,
  output logic [SW-1:0] iss_size,
  output logic [SW-1:0] rsp_off,
  output logic [SW-1:0] rsp_len
);
  // byte offset of a part inside the whole access
  function automatic logic [SW-1:0] f_off(input logic part, input logic [SW-1:0] lo);
    return part ? lo : '0;
  endfunction

  // byte count of a part
  function automatic logic [SW-1:0] f_len(input logic part, input logic sp,
                                          input logic [SW-1:0] tot, input logic [SW-1:0] lo);
    if (part) return tot - lo;
    return sp ? lo : tot;
  endfunction

  assign iss_addr = base_addr + AW'(f_off(iss_part, lo_size));
  assign iss_size = f_len(iss_part, split, total, lo_size);
  assign rsp_off  = f_off(rsp_part, lo_size);
  assign rsp_len  = f_len(rsp_part, split, total, lo_size);
endmodule

// File: rtl/sat_count.sv
module sat_count #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec_rsp,
  input  logic          dec_refuse,
  output logic [CW-1:0] cnt_q,
  output logic [CW-1:0] cnt_nxt
);
  always_comb begin
    if (load) cnt_nxt = load_val;
    else      cnt_nxt = cnt_q - CW'(dec_rsp) - CW'(dec_refuse);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/sat_merge.sv
module sat_merge #(
  parameter int DB = 8,
  parameter int SW = 4,
  localparam int DW = DB * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          upd,
  input  logic [SW-1:0] off,
  input  logic [SW-1:0] len,
  input  logic [DW-1:0] rsp_data,
  output logic [DW-1:0] merged
);
  logic [DW-1:0] shifted;

  function automatic logic lane_hit(input int lane, input logic [SW-1:0] o, input logic [SW-1:0] l);
    return (lane >= int'(o)) && (lane < int'(o) + int'(l));
  endfunction

  always_comb shifted = rsp_data << (8 * int'(off));

  for (genvar b = 0; b < DB; b++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n)                          lane_q <= '0;
      else if (clear)                      lane_q <= '0;
      else if (upd && lane_hit(b, off, len)) lane_q <= shifted[b*8 +: 8];
    end
    assign merged[b*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/sat_tracker.sv
module sat_tracker
  import sat_pkg::*;
#(
  parameter int AW = 32,
  parameter int DB = 8,
  localparam int SW = $clog2(DB + 1),
  localparam int DW = DB * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [SW-1:0] req_size,
  input  logic          req_split,
  input  logic [SW-1:0] req_lo_size,
  input  logic          req_linked,
  output logic          pa_valid,
  output logic          pa_part,
  output logic [AW-1:0] pa_addr,
  output logic [SW-1:0] pa_size,
  input  logic          pa_accept,
  input  logic          rsp_valid,
  input  logic          rsp_part,
  input  logic [DW-1:0] rsp_data,
  output logic          retry,
  output logic          done,
  output logic [AW-1:0] done_addr,
  output logic [SW-1:0] done_size,
  output logic [DW-1:0] done_data,
  output logic [1:0]    ports_used
);
  sat_state_e    st_q, st_d;
  logic [AW-1:0] addr_q;
  logic [SW-1:0] size_q, lo_q;
  logic          split_q, linked_q;
  logic [1:0]    used_q;
  logic          retry_q, done_q;

  // named internal events
  logic in_idle, in_lo, in_hi, in_wait, in_flight;
  logic ev_req_fire, ev_lo_ok, ev_lo_nack, ev_hi_nack, ev_rsp, ev_finish;
  logic [1:0] outstanding, cnt_nxt;
  logic [SW-1:0] rsp_off, rsp_len;

  assign in_idle   = (st_q == ST_IDLE);
  assign in_lo     = (st_q == ST_LO);
  assign in_hi     = (st_q == ST_HI);
  assign in_wait   = (st_q == ST_WAIT);
  assign in_flight = in_hi || in_wait;

  assign ev_req_fire = req_valid && in_idle;
  assign ev_lo_ok    = in_lo && pa_accept;
  assign ev_lo_nack  = in_lo && !pa_accept;
  assign ev_hi_nack  = in_hi && !pa_accept;
  assign ev_rsp      = rsp_valid && in_flight;
  assign ev_finish   = in_flight && (cnt_nxt == 2'd0);

  sat_planner #(.AW(AW), .SW(SW)) u_plan (
    .base_addr (addr_q),
    .total     (size_q),
    .lo_size   (lo_q),
    .split     (split_q),
    .iss_part  (in_hi),
    .rsp_part  (rsp_part),
    .iss_addr  (pa_addr),
    .iss_size  (pa_size),
    .rsp_off   (rsp_off),
    .rsp_len   (rsp_len)
  );

  sat_count #(.CW(2)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (ev_lo_ok),
    .load_val   (split_q ? 2'd2 : 2'd1),
    .dec_rsp    (ev_rsp),
    .dec_refuse (ev_hi_nack),
    .cnt_q      (outstanding),
    .cnt_nxt    (cnt_nxt)
  );

  sat_merge #(.DB(DB), .SW(SW)) u_merge (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (ev_req_fire),
    .upd      (ev_rsp),
    .off      (rsp_off),
    .len      (rsp_len),
    .rsp_data (rsp_data),
    .merged   (done_data)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (ev_req_fire) st_d = ST_LO;
      ST_LO:   st_d = pa_accept ? (split_q ? ST_HI : ST_WAIT) : ST_IDLE;
      ST_HI:   st_d = ev_finish ? ST_IDLE : ST_WAIT;
      ST_WAIT: if (ev_finish) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      size_q   <= '0;
      lo_q     <= '0;
      split_q  <= 1'b0;
      linked_q <= 1'b0;
      used_q   <= '0;
      retry_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      retry_q <= ev_lo_nack || ev_hi_nack;
      done_q  <= ev_finish;
      if (ev_req_fire) begin
        addr_q   <= req_addr;
        size_q   <= req_size;
        lo_q     <= req_lo_size;
        split_q  <= req_split && !req_linked;
        linked_q <= req_linked;
        used_q   <= '0;
      end else if (in_lo || in_hi) begin
        used_q <= used_q + 2'd1;
      end
    end
  end

  assign req_ready  = in_idle;
  assign pa_valid   = in_lo || in_hi;
  assign pa_part    = in_hi ? PART_HI : PART_LO;
  assign retry      = retry_q;
  assign done       = done_q;
  assign done_addr  = addr_q;
  assign done_size  = size_q;
  assign ports_used = used_q;
endmodule

// File: rtl/sat_checker.sv
module sat_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pa_valid,
  input logic       pa_part,
  input logic       pa_accept,
  input logic       retry,
  input logic       done,
  input logic [1:0] outstanding,
  input logic       linked_q,
  input logic [1:0] ports_used
);
  assert_hi_after_lo_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && pa_part) |-> $past(pa_valid && !pa_part && pa_accept));

  assert_lo_refuse_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && !pa_part && !pa_accept) |=> (retry && !pa_valid));

  assert_hi_refuse_retry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && pa_part && !pa_accept) |=> retry);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= 2'd2);

  assert_ports_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ports_used <= 2'd2);

  assert_linked_unsplit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_valid && pa_part) |-> !linked_q);
endmodule

bind sat_tracker sat_checker u_sat_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pa_valid    (pa_valid),
  .pa_part     (pa_part),
  .pa_accept   (pa_accept),
  .retry       (retry),
  .done        (done),
  .outstanding (outstanding),
  .linked_q    (linked_q),
  .ports_used  (ports_used)
);

// File: tb/sat_tracker_bench.sv
`timescale 1ns/1ps
module sat_tracker_bench;
  localparam int AW = 32;
  localparam int DB = 8;
  localparam int SW = $clog2(DB + 1);
  localparam int DW = DB * 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_split = 1'b0, req_linked = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [SW-1:0] req_size = '0, req_lo_size = '0;
  logic pa_accept = 1'b0, rsp_valid = 1'b0, rsp_part = 1'b0;
  logic [DW-1:0] rsp_data = '0;
  logic req_ready, pa_valid, pa_part, retry, done;
  logic [AW-1:0] pa_addr, done_addr;
  logic [SW-1:0] pa_size, done_size;
  logic [DW-1:0] done_data;
  logic [1:0] ports_used;

  always #2 clk = ~clk;

  sat_tracker #(.AW(AW), .DB(DB)) u_sat_tracker (.*);

  int total = 0, bad = 0, cyc = 0, done_cnt = 0;
  bit run = 0, expect_full = 0;
  // scenario values for the responder
  logic [31:0] s_addr;
  int s_size, s_lo;
  bit s_split;

  // reference model state
  int ms = 0, mcnt = 0, mused = 0;
  bit mretry = 0, mdone = 0, msplit = 0;
  logic [31:0] maddr = 0;
  int msize = 0, mlo = 0;
  logic [63:0] mdata = 0;

  function automatic logic [7:0] pat(input logic [31:0] a);
    return 8'(a * 3 + 17);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic m_merge(input bit part, input logic [63:0] d);
    int off, len;
    off = part ? mlo : 0;
    len = part ? msize - mlo : (msplit ? mlo : msize);
    for (int b = 0; b < len; b++)
      if (off + b < DB) mdata[(off + b) * 8 +: 8] = d[b * 8 +: 8];
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      ms = 0; mcnt = 0; mused = 0; mretry = 0; mdone = 0; mdata = 0;
    end else begin
      mretry = 0; mdone = 0;
      case (ms)
        0: if (req_valid) begin
             maddr = req_addr; msize = int'(req_size); mlo = int'(req_lo_size);
             msplit = req_split && !req_linked; mdata = 0; mused = 0; ms = 1;
           end
        1: begin
             mused++;
             if (pa_accept) begin mcnt = msplit ? 2 : 1; ms = msplit ? 2 : 3; end
             else begin mretry = 1; ms = 0; end
           end
        2: begin
             mused++;
             if (rsp_valid) begin m_merge(rsp_part, rsp_data); mcnt--; end
             if (!pa_accept) begin mcnt--; mretry = 1; end
             if (mcnt == 0) begin mdone = 1; ms = 0; end else ms = 3;
           end
        default: if (rsp_valid) begin
             m_merge(rsp_part, rsp_data); mcnt--;
             if (mcnt == 0) begin mdone = 1; ms = 0; end
           end
      endcase
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (run) begin
      logic [31:0] ea;
      int es;
      ea = (ms == 2) ? maddr + 32'(mlo) : maddr;
      es = (ms == 2) ? msize - mlo : (msplit ? mlo : msize);
      chk(req_ready === (ms == 0), "R3 ready", 64'(req_ready), 64'(ms == 0));
      chk(pa_valid === (ms == 1 || ms == 2), "R2 pa_valid", 64'(pa_valid), 64'(ms == 1 || ms == 2));
      if (ms == 1 || ms == 2) begin
        chk(pa_part === (ms == 2), "R2 pa_part", 64'(pa_part), 64'(ms == 2));
        chk(pa_addr === ea, "R1 pa_addr", 64'(pa_addr), 64'(ea));
        chk(int'(pa_size) == es, "R1 pa_size", 64'(pa_size), 64'(es));
      end
      chk(retry === mretry, "R5 R6 retry", 64'(retry), 64'(mretry));
      chk(done === mdone, "R4 done", 64'(done), 64'(mdone));
      chk(ports_used === 2'(mused), "R7 ports_used", 64'(ports_used), 64'(mused));
      if (mdone && done) begin
        chk(done_data === mdata, "R8 done_data", done_data, mdata);
        chk(done_addr === maddr, "R8 done_addr", 64'(done_addr), 64'(maddr));
        chk(int'(done_size) == msize, "R8 done_size", 64'(done_size), 64'(msize));
        if (expect_full)
          for (int i = 0; i < msize; i++)
            chk(done_data[i*8 +: 8] === pat(maddr + 32'(i)), "R1 byte placement",
                64'(done_data[i*8 +: 8]), 64'(pat(maddr + 32'(i))));
      end
      if (done) done_cnt++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  task automatic send_rsp(input bit part);
    logic [31:0] a;
    int len;
    a   = part ? s_addr + 32'(s_lo) : s_addr;
    len = part ? s_size - s_lo : (s_split ? s_lo : s_size);
    rsp_valid = 1'b1; rsp_part = part;
    for (int b = 0; b < DB; b++)
      rsp_data[b*8 +: 8] = (b < len) ? pat(a + 32'(b)) : 8'hEE;
  endtask

  task automatic rsp_cycle(input bit part);
    send_rsp(part);
    @(negedge clk);
    rsp_valid = 1'b0;
  endtask

  task automatic run_access(input logic [31:0] a, input int sz, input bit sp, input int lo,
                            input bit lk, input bit acc_lo, input bit acc_hi,
                            input bit hi_first, input bit early_lo, input bit stray_lo);
    int d0;
    s_addr = a; s_size = sz; s_lo = lo; s_split = sp && !lk;
    expect_full = acc_lo && (!s_split || acc_hi);
    d0 = done_cnt;
    req_valid = 1'b1; req_addr = a; req_size = SW'(sz); req_split = sp;
    req_lo_size = SW'(lo); req_linked = lk;
    @(negedge clk);
    req_valid = 1'b0;
    pa_accept = acc_lo;
    if (stray_lo) send_rsp(1'b0);   // R10: ignored while first part is presented
    @(negedge clk);
    pa_accept = 1'b0; rsp_valid = 1'b0;
    if (acc_lo) begin
      if (s_split) begin
        pa_accept = acc_hi;
        if (early_lo) send_rsp(1'b0);
        @(negedge clk);
        pa_accept = 1'b0; rsp_valid = 1'b0;
      end
      if (s_split && acc_hi && hi_first) rsp_cycle(1'b1);
      if (!(s_split && early_lo)) rsp_cycle(1'b0);
      if (s_split && acc_hi && !hi_first) rsp_cycle(1'b1);
    end
    repeat (2) @(negedge clk);
    chk(ports_used == ((s_split && acc_lo) ? 2'd2 : 2'd1), "R7 final ports_used",
        64'(ports_used), 64'((s_split && acc_lo) ? 2 : 1));
    chk(done_cnt - d0 == (acc_lo ? 1 : 0), "R4 R5 done count",
        64'(done_cnt - d0), 64'(acc_lo ? 1 : 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !pa_valid && !done && !retry && ports_used == 0, "R3 reset state",
        64'({req_ready, pa_valid, done, retry}), 64'b1000);
    run = 1;
    // unsplit access: single full sub-request (R3)
    run_access(32'h100, 4, 0, 0, 0, 1, 1, 0, 0, 0);
    // split, low response first (R1, R2, R4, R8)
    run_access(32'h1FD, 8, 1, 3, 0, 1, 1, 0, 0, 0);
    // split, high response first
    run_access(32'h2FF, 2, 1, 1, 0, 1, 1, 1, 0, 0);
    // low refused: dropped, retry (R5)
    run_access(32'h3FB, 8, 1, 5, 0, 0, 1, 0, 0, 0);
    // high refused: retry, completes on low (R6)
    run_access(32'h4FE, 4, 1, 2, 0, 1, 0, 0, 0, 0);
    // low response during the high-part cycle, high accepted
    run_access(32'h5FA, 7, 1, 6, 0, 1, 1, 0, 1, 0);
    // low response coincides with high refusal (R6)
    run_access(32'h6FC, 6, 1, 4, 0, 1, 0, 0, 1, 0);
    // load-linked with split flag stays unsplit (R9)
    run_access(32'h7FE, 4, 1, 2, 1, 1, 1, 0, 0, 0);
    // stray responses: while idle and while first part is presented (R10)
    send_rsp(1'b1);
    @(negedge clk);
    rsp_valid = 1'b0;
    chk(!done && req_ready, "R10 idle stray", 64'({done, req_ready}), 64'b01);
    run_access(32'h800, 8, 1, 4, 0, 1, 1, 1, 0, 1);
    // sweep of sizes, split points and orders
    for (int k = 0; k < 14; k++) begin
      int sz, lo;
      sz = 2 + (k % 7);
      lo = 1 + (k % (sz - 1));
      run_access(32'h1000 + 32'(k * 13), sz, 1'(k % 4 != 3), lo, 1'(k == 5),
                 1'(k % 5 != 4), 1'(k % 3 != 2), 1'(k % 2), 1'(k % 6 == 1), 1'(k == 8));
    end
    run = 0;
    report();
  end
endmodule